// File: doc/BRIEF.md
# Indexed Dual-Core Converter Configuration Register Bank

This block holds the configuration state of a data converter with two cores. Accesses arrive one byte at a time from a serial shifter. Each access carries an 8-bit address, a write flag and a first-beat flag. The bank applies writes and returns read bytes on a response channel. From its register contents it drives trim and power-mode outputs for each core.

Some registers are global. The others are indexed: each core has its own copy, and a core-select register decides which copy an access reaches. The power-up trim values of each core come from a calibration load port. The bank latches those values so that a soft reset can restore them. The power-mode register of a core can hand control to a global tri-level pin decode.

A burst continues from the previous address. Each non-first beat steps the address by one. Once the address has reached the programmable end address, further beats of that burst are dropped.

Top module: `cvt_cfg_bank`

## Requirements
- R1: After reset, `rsp_valid` is 0, the core-select register (0x10) reads 0x00, the burst end register (0x02) reads 0x00, and every trim output equals its parameter default (offsets and medium/fine gains 0x80, coarse gain 0x0). Both cores follow the pin decode.
- R2: Address 0x08 reads the `CHIP_ID` parameter and address 0x09 reads the `CHIP_REV` parameter. Writes to these two addresses change nothing.
- R3: The core-select register at 0x10 stores write bits 1:0 and reads back with bits 7:2 zero. Only 2'b01 (core 0) and 2'b10 (core 1) count as a valid selection. 2'b00 and 2'b11 are stored, but they select no core.
- R4: While the selection is not valid, a read of any indexed address (0x20 to 0x25) returns 0xAD, and a write to one of them changes nothing.
- R5: Indexed registers are per core: coarse offset 0x20, fine offset 0x21, coarse gain 0x22 (bits 3:0, bits 7:4 read 0), medium gain 0x23, fine gain 0x24, and power mode 0x25 (bits 2:0, bits 7:3 read 0). A write reaches only the selected core, and that core's output shows the new value one cycle later.
- R6: A `cal_valid` pulse loads the five trim fields of core `cal_core` into that core's live registers and also into its latched defaults.
- R7: Writing a byte with bit 0 set to address 0x00 is a soft reset. It clears the core-select and burst end registers and reloads every core's trims from its latched defaults. It leaves the power-mode registers unchanged. Address 0x00 reads 0x00.
- R8: A core whose power-mode register holds 000 takes `pin_pwr`: 0 is normal, 1 is nap, 2 is sleep, and 3 is normal. Any other value drives that core by its own register: bit 2 gives sleep, otherwise bit 1 gives nap, otherwise normal. `core_pwr` is encoded 0 = normal, 1 = nap, 2 = sleep.
- R9: A beat with `req_first`=1 uses `req_addr`. A beat with `req_first`=0 uses the previous effective address plus one, provided the previous beat was not dropped and its address was below the burst end register. Otherwise the beat is dropped: a dropped write does nothing, a dropped read returns 0x00, and the burst stays dropped until the next first beat.
- R10: Unmapped addresses read 0x00, and writes to them change nothing.
- R11: A request transfers when `req_valid` and `req_ready` are both high. `req_ready` is high whenever no response is pending or `rsp_ready` is high. An accepted read raises `rsp_valid` in the next cycle. `rsp_valid` and `rsp_data` hold unchanged until `rsp_ready` is high. Writes produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access beat offered |
| req_ready | output | 1 | Bank can take a beat |
| req_first | input | 1 | Beat starts a transfer at `req_addr` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Address, used on first beats |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Read byte available |
| rsp_ready | input | 1 | Consumer takes the read byte |
| rsp_data | output | 8 | Read byte |
| cal_valid | input | 1 | Calibration load strobe |
| cal_core | input | 1 | Core receiving the calibration values |
| cal_coarse_off | input | 8 | Calibrated coarse offset |
| cal_fine_off | input | 8 | Calibrated fine offset |
| cal_coarse_gain | input | 4 | Calibrated coarse gain |
| cal_med_gain | input | 8 | Calibrated medium gain |
| cal_fine_gain | input | 8 | Calibrated fine gain |
| pin_pwr | input | 2 | Decoded tri-level power pin |
| core_coarse_off | output | 2x8 | Per-core coarse offset |
| core_fine_off | output | 2x8 | Per-core fine offset |
| core_coarse_gain | output | 2x4 | Per-core coarse gain |
| core_med_gain | output | 2x8 | Per-core medium gain |
| core_fine_gain | output | 2x8 | Per-core fine gain |
| core_pwr | output | 2x2 | Per-core power state |

## Verification
The assertions assume that the request fields are meaningful only while `req_valid` is high. They also assume that a calibration load never lands in the same cycle as a bus write or soft reset aimed at the same core's trims, because the bank gives the calibration load priority in that case. The stimulus drives calibration loads only in cycles with no beat in flight. It holds `req_valid` low while it stalls `rsp_ready`, so back-pressure never overlaps a new offer. Random beats mix first and continuation flags, so bursts both run to their end address and are dropped.

// File: rtl/cvt_cfg_pkg.sv
package cvt_cfg_pkg;
  localparam logic [7:0] A_CTRL  = 8'h00;
  localparam logic [7:0] A_BEND  = 8'h02;
  localparam logic [7:0] A_ID    = 8'h08;
  localparam logic [7:0] A_REV   = 8'h09;
  localparam logic [7:0] A_SEL   = 8'h10;
  localparam logic [7:0] A_COFF  = 8'h20;
  localparam logic [7:0] A_FOFF  = 8'h21;
  localparam logic [7:0] A_CGAIN = 8'h22;
  localparam logic [7:0] A_MGAIN = 8'h23;
  localparam logic [7:0] A_FGAIN = 8'h24;
  localparam logic [7:0] A_PMODE = 8'h25;
  localparam logic [7:0] ERR_BYTE = 8'hAD;

  typedef enum logic [1:0] {
    PWR_NORMAL = 2'd0,
    PWR_NAP    = 2'd1,
    PWR_SLEEP  = 2'd2
  } pwr_e;

  typedef struct packed {
    logic [7:0] coff;
    logic [7:0] foff;
    logic [3:0] cgain;
    logic [7:0] mgain;
    logic [7:0] fgain;
  } trim_t;

  function automatic logic is_indexed(input logic [7:0] a);
    return (a >= A_COFF) && (a <= A_PMODE);
  endfunction

  function automatic pwr_e pin_decode(input logic [1:0] p);
    case (p)
      2'd1:    return PWR_NAP;
      2'd2:    return PWR_SLEEP;
      default: return PWR_NORMAL;
    endcase
  endfunction

  function automatic pwr_e mode_decode(input logic [2:0] m);
    if (m[2])      return PWR_SLEEP;
    else if (m[1]) return PWR_NAP;
    else           return PWR_NORMAL;
  endfunction
endpackage

// File: rtl/cvt_cfg_addr_seq.sv
module cvt_cfg_addr_seq #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          beat,
  input  logic          first,
  input  logic [AW-1:0] req_addr,
  input  logic [AW-1:0] end_addr,
  output logic [AW-1:0] eff_addr,
  output logic          beat_ok
);
  logic [AW-1:0] cur_q;
  logic          live_q;

  always_comb begin
    if (first) begin
      eff_addr = req_addr;
      beat_ok  = 1'b1;
    end else begin
      eff_addr = cur_q + AW'(1);
      beat_ok  = live_q && (cur_q < end_addr);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      live_q <= 1'b0;
    end else if (beat) begin
      live_q <= beat_ok;
      if (beat_ok) cur_q <= eff_addr;
    end
  end
endmodule

// File: rtl/cvt_cfg_core_regs.sv
module cvt_cfg_core_regs
  import cvt_cfg_pkg::*;
#(
  parameter trim_t DEF = '0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       soft_rst,
  input  logic       cal_ld,
  input  trim_t      cal_val,
  input  logic       wr_en,
  input  logic [7:0] addr,
  input  logic [7:0] wr_data,
  output trim_t      trim,
  output logic [2:0] pmode,
  output logic [7:0] rd_data
);
  trim_t shadow_q;
  trim_t live_q;
  logic [2:0] pmode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= DEF;
      live_q   <= DEF;
    end else if (cal_ld) begin
      shadow_q <= cal_val;
      live_q   <= cal_val;
    end else if (soft_rst) begin
      live_q <= shadow_q;
    end else if (wr_en) begin
      case (addr)
        A_COFF:  live_q.coff  <= wr_data;
        A_FOFF:  live_q.foff  <= wr_data;
        A_CGAIN: live_q.cgain <= wr_data[3:0];
        A_MGAIN: live_q.mgain <= wr_data;
        A_FGAIN: live_q.fgain <= wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          pmode_q <= 3'b000;
    else if (wr_en && addr == A_PMODE)   pmode_q <= wr_data[2:0];
  end

  always_comb begin
    case (addr)
      A_COFF:  rd_data = live_q.coff;
      A_FOFF:  rd_data = live_q.foff;
      A_CGAIN: rd_data = {4'b0, live_q.cgain};
      A_MGAIN: rd_data = live_q.mgain;
      A_FGAIN: rd_data = live_q.fgain;
      A_PMODE: rd_data = {5'b0, pmode_q};
      default: rd_data = 8'h00;
    endcase
  end

  assign trim  = live_q;
  assign pmode = pmode_q;
endmodule

// File: rtl/cvt_cfg_pwr_sel.sv
module cvt_cfg_pwr_sel
  import cvt_cfg_pkg::*;
#(
  parameter int NUM_CORES = 2
) (
  input  logic [1:0]                 pin_pwr,
  input  logic [NUM_CORES-1:0][2:0]  pmode,
  output logic [NUM_CORES-1:0][1:0]  core_pwr
);
  pwr_e pin_state;
  assign pin_state = pin_decode(pin_pwr);

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    pwr_e st;
    always_comb begin
      if (pmode[c] == 3'b000) st = pin_state;
      else                    st = mode_decode(pmode[c]);
    end
    assign core_pwr[c] = st;
  end
endmodule

// File: rtl/cvt_cfg_bank.sv
module cvt_cfg_bank
  import cvt_cfg_pkg::*;
#(
  parameter int         NUM_CORES = 2,
  parameter logic [7:0] CHIP_ID   = 8'h4C,
  parameter logic [7:0] CHIP_REV  = 8'h01,
  parameter logic [7:0] DEF_OFF   = 8'h80,
  parameter logic [3:0] DEF_CGAIN = 4'h0,
  parameter logic [7:0] DEF_GAIN  = 8'h80,
  localparam int        CW        = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic                       req_first,
  input  logic                       req_write,
  input  logic [7:0]                 req_addr,
  input  logic [7:0]                 req_wdata,
  output logic                       rsp_valid,
  input  logic                       rsp_ready,
  output logic [7:0]                 rsp_data,
  input  logic                       cal_valid,
  input  logic [CW-1:0]              cal_core,
  input  logic [7:0]                 cal_coarse_off,
  input  logic [7:0]                 cal_fine_off,
  input  logic [3:0]                 cal_coarse_gain,
  input  logic [7:0]                 cal_med_gain,
  input  logic [7:0]                 cal_fine_gain,
  input  logic [1:0]                 pin_pwr,
  output logic [NUM_CORES-1:0][7:0]  core_coarse_off,
  output logic [NUM_CORES-1:0][7:0]  core_fine_off,
  output logic [NUM_CORES-1:0][3:0]  core_coarse_gain,
  output logic [NUM_CORES-1:0][7:0]  core_med_gain,
  output logic [NUM_CORES-1:0][7:0]  core_fine_gain,
  output logic [NUM_CORES-1:0][1:0]  core_pwr
);
  localparam trim_t DEF_TRIM = '{coff: DEF_OFF, foff: DEF_OFF, cgain: DEF_CGAIN,
                                 mgain: DEF_GAIN, fgain: DEF_GAIN};

  logic                      beat, wr_fire, rd_fire, soft_rst, beat_ok, idx_ok;
  logic [7:0]                eff_addr, bend_q, rd_mux, core_rd_sel;
  logic [NUM_CORES-1:0]      idx_q;
  logic [NUM_CORES-1:0][2:0] pmode_q;
  logic [NUM_CORES-1:0][7:0] core_rd;
  trim_t                     cal_trim;
  trim_t [NUM_CORES-1:0]     trim_q;

  assign req_ready = !rsp_valid || rsp_ready;
  assign beat      = req_valid && req_ready;
  assign wr_fire   = beat && req_write && beat_ok;
  assign rd_fire   = beat && !req_write;
  assign soft_rst  = wr_fire && (eff_addr == A_CTRL) && req_wdata[0];
  assign idx_ok    = $onehot(idx_q);
  assign cal_trim  = '{coff: cal_coarse_off, foff: cal_fine_off, cgain: cal_coarse_gain,
                       mgain: cal_med_gain, fgain: cal_fine_gain};

  cvt_cfg_addr_seq #(.AW(8)) seq_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .beat     (beat),
    .first    (req_first),
    .req_addr (req_addr),
    .end_addr (bend_q),
    .eff_addr (eff_addr),
    .beat_ok  (beat_ok)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      bend_q <= 8'h00;
    end else if (soft_rst) begin
      idx_q  <= '0;
      bend_q <= 8'h00;
    end else if (wr_fire) begin
      if (eff_addr == A_SEL)  idx_q  <= req_wdata[NUM_CORES-1:0];
      if (eff_addr == A_BEND) bend_q <= req_wdata;
    end
  end

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    logic cal_ld, wr_en;
    assign cal_ld = cal_valid && (cal_core == CW'(c));
    assign wr_en  = wr_fire && is_indexed(eff_addr) && idx_ok && idx_q[c];

    cvt_cfg_core_regs #(.DEF(DEF_TRIM)) regs_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_rst (soft_rst),
      .cal_ld   (cal_ld),
      .cal_val  (cal_trim),
      .wr_en    (wr_en),
      .addr     (eff_addr),
      .wr_data  (req_wdata),
      .trim     (trim_q[c]),
      .pmode    (pmode_q[c]),
      .rd_data  (core_rd[c])
    );

    assign core_coarse_off[c]  = trim_q[c].coff;
    assign core_fine_off[c]    = trim_q[c].foff;
    assign core_coarse_gain[c] = trim_q[c].cgain;
    assign core_med_gain[c]    = trim_q[c].mgain;
    assign core_fine_gain[c]   = trim_q[c].fgain;
  end

  cvt_cfg_pwr_sel #(.NUM_CORES(NUM_CORES)) pwr_i (
    .pin_pwr  (pin_pwr),
    .pmode    (pmode_q),
    .core_pwr (core_pwr)
  );

  always_comb begin
    core_rd_sel = 8'h00;
    for (int c = 0; c < NUM_CORES; c++)
      if (idx_q[c]) core_rd_sel = core_rd_sel | core_rd[c];
  end

  always_comb begin
    rd_mux = 8'h00;
    if (beat_ok) begin
      if (is_indexed(eff_addr)) rd_mux = idx_ok ? core_rd_sel : ERR_BYTE;
      else begin
        case (eff_addr)
          A_ID:    rd_mux = CHIP_ID;
          A_REV:   rd_mux = CHIP_REV;
          A_SEL:   rd_mux = 8'(idx_q);
          A_BEND:  rd_mux = bend_q;
          default: rd_mux = 8'h00;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= 8'h00;
    end else if (rd_fire) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rd_mux;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/cvt_cfg_bank_chk.sv
module cvt_cfg_bank_chk #(
  parameter int         NUM_CORES = 2,
  parameter logic [7:0] CHIP_ID   = 8'h4C
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      req_valid,
  input logic                      req_ready,
  input logic                      req_first,
  input logic                      req_write,
  input logic [7:0]                req_addr,
  input logic                      rsp_valid,
  input logic                      rsp_ready,
  input logic [7:0]                rsp_data,
  input logic [1:0]                pin_pwr,
  input logic [NUM_CORES-1:0][1:0] core_pwr,
  input logic [NUM_CORES-1:0]      idx_q,
  input logic                      idx_ok,
  input logic                      soft_rst,
  input logic [NUM_CORES-1:0][2:0] pmode_q
);
  logic rd_first;
  assign rd_first = req_valid && req_ready && !req_write && req_first;

  // R11
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

  // R11
  rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_write |=> rsp_valid);

  // R2
  chip_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_first && req_addr == 8'h08 |=> rsp_data == CHIP_ID);

  // R4
  err_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_first && req_addr >= 8'h20 && req_addr <= 8'h25 && !idx_ok |=> rsp_data == 8'hAD);

  // R7
  soft_sel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> idx_q == '0);

  // R7
  soft_pmode_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> $stable(pmode_q));

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_pwr
    // R8
    pwr_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      core_pwr[c] != 2'b11);
    // R8
    pin_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pmode_q[c] == 3'b000 |-> core_pwr[c] == ((pin_pwr == 2'd1) ? 2'd1 :
                                               (pin_pwr == 2'd2) ? 2'd2 : 2'd0));
  end
endmodule

bind cvt_cfg_bank cvt_cfg_bank_chk #(.NUM_CORES(NUM_CORES), .CHIP_ID(CHIP_ID)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_first (req_first),
  .req_write (req_write),
  .req_addr  (req_addr),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_data  (rsp_data),
  .pin_pwr   (pin_pwr),
  .core_pwr  (core_pwr),
  .idx_q     (idx_q),
  .idx_ok    (idx_ok),
  .soft_rst  (soft_rst),
  .pmode_q   (pmode_q)
);

// File: tb/cvt_cfg_bank_tb_top.sv
module cvt_cfg_bank_tb_top;
  localparam int NC = 2;
  localparam logic [7:0] ID = 8'h4C, REV = 8'h01;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_first = 0, req_write = 0, rsp_ready = 1, cal_valid = 0;
  logic [7:0] req_addr = 0, req_wdata = 0;
  logic req_ready, rsp_valid;
  logic [7:0] rsp_data;
  logic [0:0] cal_core = 0;
  logic [7:0] cal_co = 0, cal_fo = 0, cal_mg = 0, cal_fg = 0;
  logic [3:0] cal_cg = 0;
  logic [1:0] pin_pwr = 0;
  logic [NC-1:0][7:0] o_co, o_fo, o_mg, o_fg;
  logic [NC-1:0][3:0] o_cg;
  logic [NC-1:0][1:0] o_pwr;

  always #2 clk = ~clk;

  cvt_cfg_bank dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_first(req_first), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .cal_valid(cal_valid), .cal_core(cal_core), .cal_coarse_off(cal_co), .cal_fine_off(cal_fo),
    .cal_coarse_gain(cal_cg), .cal_med_gain(cal_mg), .cal_fine_gain(cal_fg), .pin_pwr(pin_pwr),
    .core_coarse_off(o_co), .core_fine_off(o_fo), .core_coarse_gain(o_cg),
    .core_med_gain(o_mg), .core_fine_gain(o_fg), .core_pwr(o_pwr)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  logic [1:0] m_idx;
  logic [7:0] m_bend, m_cur;
  bit m_blive;
  logic [7:0] m_co[NC], m_fo[NC], m_mg[NC], m_fg[NC];
  logic [3:0] m_cg[NC];
  logic [7:0] s_co[NC], s_fo[NC], s_mg[NC], s_fg[NC];
  logic [3:0] s_cg[NC];
  logic [2:0] m_pm[NC];

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit sel_ok();
    return m_idx == 2'b01 || m_idx == 2'b10;
  endfunction

  function automatic logic [1:0] exp_pwr(input int c);
    if (m_pm[c] == 3'b000) return (pin_pwr == 2'd1) ? 2'd1 : (pin_pwr == 2'd2) ? 2'd2 : 2'd0;
    if (m_pm[c][2]) return 2'd2;
    if (m_pm[c][1]) return 2'd1;
    return 2'd0;
  endfunction

  function automatic logic [7:0] model_read(input logic [7:0] a);
    int c;
    c = (m_idx == 2'b10) ? 1 : 0;
    if (a >= 8'h20 && a <= 8'h25 && !sel_ok()) return 8'hAD;
    case (a)
      8'h02: return m_bend;
      8'h08: return ID;
      8'h09: return REV;
      8'h10: return {6'b0, m_idx};
      8'h20: return m_co[c];
      8'h21: return m_fo[c];
      8'h22: return {4'b0, m_cg[c]};
      8'h23: return m_mg[c];
      8'h24: return m_fg[c];
      8'h25: return {5'b0, m_pm[c]};
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_write(input logic [7:0] a, input logic [7:0] d);
    int c;
    c = (m_idx == 2'b10) ? 1 : 0;
    if (a == 8'h00 && d[0]) begin
      m_idx = 0; m_bend = 0;
      for (int k = 0; k < NC; k++) begin
        m_co[k] = s_co[k]; m_fo[k] = s_fo[k]; m_cg[k] = s_cg[k]; m_mg[k] = s_mg[k]; m_fg[k] = s_fg[k];
      end
    end else if (a == 8'h02) m_bend = d;
    else if (a == 8'h10) m_idx = d[1:0];
    else if (a >= 8'h20 && a <= 8'h25 && sel_ok()) begin
      case (a)
        8'h20: m_co[c] = d;
        8'h21: m_fo[c] = d;
        8'h22: m_cg[c] = d[3:0];
        8'h23: m_mg[c] = d;
        8'h24: m_fg[c] = d;
        default: m_pm[c] = d[2:0];
      endcase
    end
  endtask

  function automatic string pick_tag(input logic [7:0] a, input bit ok);
    if (!ok) return "R9";
    if (a == 8'h08 || a == 8'h09) return "R2";
    if (a == 8'h10) return "R3";
    if (a >= 8'h20 && a <= 8'h25) return sel_ok() ? "R5" : "R4";
    if (a == 8'h00 || a == 8'h02) return "R7";
    return "R10";
  endfunction

  task automatic check_outs(input string tag);
    for (int c = 0; c < NC; c++) begin
      chk(o_co[c] === m_co[c], tag, o_co[c], m_co[c]);
      chk(o_fo[c] === m_fo[c], tag, o_fo[c], m_fo[c]);
      chk(o_cg[c] === m_cg[c], tag, {4'b0, o_cg[c]}, {4'b0, m_cg[c]});
      chk(o_mg[c] === m_mg[c], tag, o_mg[c], m_mg[c]);
      chk(o_fg[c] === m_fg[c], tag, o_fg[c], m_fg[c]);
      chk(o_pwr[c] === exp_pwr(c), (tag == "R1") ? "R1" : "R8", {6'b0, o_pwr[c]}, {6'b0, exp_pwr(c)});
    end
  endtask

  task automatic beat(input bit first, input bit wr, input logic [7:0] addr,
                      input logic [7:0] wd, input string tag_in);
    logic [7:0] eff, exp;
    bit ok;
    string tag;
    if (first) begin eff = addr; ok = 1; end
    else begin ok = m_blive && (m_cur < m_bend); eff = m_cur + 8'd1; end
    exp = ok ? model_read(eff) : 8'h00;
    tag = (tag_in != "") ? tag_in : pick_tag(eff, ok);
    req_valid = 1; req_first = first; req_write = wr; req_addr = addr; req_wdata = wd;
    @(posedge clk);
    m_blive = ok;
    if (ok) m_cur = eff;
    if (wr && ok) model_write(eff, wd);
    @(negedge clk);
    req_valid = 0;
    if (!wr) begin
      chk(rsp_valid === 1'b1, "R11", {7'b0, rsp_valid}, 8'h01);
      chk(rsp_data === exp, tag, rsp_data, exp);
    end
    check_outs(tag);
  endtask

  task automatic cal_load(input int c);
    cal_core = c[0]; cal_co = 8'($urandom); cal_fo = 8'($urandom); cal_cg = 4'($urandom);
    cal_mg = 8'($urandom); cal_fg = 8'($urandom); cal_valid = 1;
    @(posedge clk);
    s_co[c] = cal_co; s_fo[c] = cal_fo; s_cg[c] = cal_cg; s_mg[c] = cal_mg; s_fg[c] = cal_fg;
    m_co[c] = cal_co; m_fo[c] = cal_fo; m_cg[c] = cal_cg; m_mg[c] = cal_mg; m_fg[c] = cal_fg;
    @(negedge clk);
    cal_valid = 0;
    check_outs("R6");
  endtask

  function automatic logic [7:0] rand_addr();
    int r;
    r = $urandom_range(0, 15);
    case (r)
      0: return 8'h00;
      1: return 8'h02;
      2: return 8'h08;
      3: return 8'h09;
      4, 5: return 8'h10;
      6, 7, 8, 9, 10, 11: return 8'h20 + 8'($urandom_range(0, 5));
      default: return 8'($urandom);
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] held;
    void'($urandom(32'd1234));
    m_idx = 0; m_bend = 0; m_cur = 0; m_blive = 0;
    for (int c = 0; c < NC; c++) begin
      m_co[c] = 8'h80; m_fo[c] = 8'h80; m_cg[c] = 4'h0; m_mg[c] = 8'h80; m_fg[c] = 8'h80; m_pm[c] = 0;
      s_co[c] = 8'h80; s_fo[c] = 8'h80; s_cg[c] = 4'h0; s_mg[c] = 8'h80; s_fg[c] = 8'h80;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(rsp_valid === 1'b0, "R1", {7'b0, rsp_valid}, 8'h00);
    check_outs("R1");
    beat(1, 0, 8'h10, 0, "R1");
    beat(1, 0, 8'h02, 0, "R1");
    beat(1, 0, 8'h23, 0, "R4");
    // R2 ID read and write ignore
    beat(1, 1, 8'h08, 8'h00, "R2");
    beat(1, 0, 8'h08, 0, "R2");
    beat(1, 0, 8'h09, 0, "R2");
    // R3 invalid index 11 stored, no selection
    beat(1, 1, 8'h10, 8'hFF, "R3");
    beat(1, 0, 8'h10, 0, "R3");
    beat(1, 1, 8'h20, 8'h11, "R4");
    beat(1, 0, 8'h20, 0, "R4");
    // R5 per-core writes
    beat(1, 1, 8'h10, 8'h01, "R3");
    beat(1, 1, 8'h22, 8'hF7, "R5");
    beat(1, 0, 8'h22, 0, "R5");
    beat(1, 1, 8'h10, 8'h02, "R3");
    beat(1, 1, 8'h20, 8'h3C, "R5");
    beat(1, 1, 8'h25, 8'h02, "R8");
    // R9 burst up to end address
    beat(1, 1, 8'h02, 8'h22, "R9");
    beat(1, 1, 8'h20, 8'h01, "R9");
    beat(0, 1, 0, 8'h02, "R9");
    beat(0, 1, 0, 8'h03, "R9");
    beat(0, 1, 0, 8'h04, "R9");
    beat(1, 0, 8'h20, 0, "R9");
    beat(0, 0, 0, 0, "R9");
    beat(0, 0, 0, 0, "R9");
    beat(0, 0, 0, 0, "R9");
    // R10 unmapped
    beat(1, 1, 8'h77, 8'h5A, "R10");
    beat(1, 0, 8'h77, 0, "R10");
    // R6 calibration, R7 soft reset keeps power mode
    cal_load(0);
    cal_load(1);
    beat(1, 1, 8'h21, 8'h99, "R5");
    beat(1, 1, 8'h00, 8'h01, "R7");
    beat(1, 0, 8'h10, 0, "R7");
    beat(1, 0, 8'h00, 0, "R7");
    beat(1, 1, 8'h10, 8'h02, "R7");
    beat(1, 0, 8'h25, 0, "R7");
    // R8 pin values
    for (int p = 0; p < 4; p++) begin
      pin_pwr = 2'(p);
      @(negedge clk);
      check_outs("R8");
    end
    // R11 back-pressure
    rsp_ready = 0;
    req_valid = 1; req_first = 1; req_write = 0; req_addr = 8'h09;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    held = rsp_data;
    chk(rsp_data === REV, "R11", rsp_data, REV);
    chk(req_ready === 1'b0, "R11", {7'b0, req_ready}, 8'h00);
    repeat (3) @(negedge clk);
    chk(rsp_valid === 1'b1 && rsp_data === held, "R11", rsp_data, held);
    rsp_ready = 1;
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R11", {7'b0, rsp_valid}, 8'h00);
    // random mix
    for (int i = 0; i < 1500; i++) begin
      int r;
      logic [7:0] a, d;
      r = $urandom_range(0, 99);
      if (r < 3) cal_load($urandom_range(0, 1));
      else if (r < 8) begin pin_pwr = 2'($urandom); @(negedge clk); check_outs("R8"); end
      else begin
        a = rand_addr();
        d = 8'($urandom);
        if (a == 8'h00) d[0] = ($urandom_range(0, 4) == 0);
        if (a == 8'h10 && $urandom_range(0, 3) != 0) d = 8'($urandom_range(1, 2));
        if (a == 8'h02) d = 8'h20 + 8'($urandom_range(0, 6));
        beat($urandom_range(0, 2) != 0, $urandom_range(0, 1) == 1, a, d, "");
      end
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule